// File: doc/BRIEF.md
# Sync-Aware Programmable Timer Counter

This block is one 16-bit counter channel of a small timer group. Software programs it through a narrow register port: a mode word, a target value and a loadable count value. The count advances once for each clock-enable pulse from the selected source. That source is either the system tick or an alternate tick, such as a pixel-rate or line-rate pulse. The count wraps either at full range or after it has reached the programmed target. A single-cycle interrupt pulse can be raised when the count becomes the target, when it overflows, or on both.

With sync enabled, a blanking input steers the count. On channels 0 and 1 the count can pause while blanking is high, or clear when blanking ends. On channel 0, the clear-on-unblank behaviour also folds the count at a line length, so the value reads as a position within the current scan line. On channel 2 the blanking input plays no part, and two of the sync codes halt the count outright. The channel number is a parameter, so the same source builds all three variants.

Top module: `sync_timer`

## Requirements
- R1: After reset the count, mode and target registers read 0 and irq_o is low.
- R2: A write with wr_sel_i=0 loads the low 16 bits of wr_data_i into the count, and the upper bits are discarded. A write with wr_sel_i=2 loads the target. Reads with rd_sel_i 0, 1 and 2 return count, mode and target, and rd_sel_i 3 returns 0.
- R3: A write with wr_sel_i=1 stores the mode and clears the count to 0. No interrupt pulse follows from a tick in the same cycle.
- R4: When mode bit 8 is 0 the count advances only on sys_tick_i. When it is 1 the count advances only on alt_tick_i.
- R5: Without a target wrap, an advance from 0xFFFF gives 0. When mode bit 5 is set, irq_o pulses high for one cycle at that step.
- R6: With mode bit 3 set, an advance taken while the count equals the target gives 0.
- R7: With mode bit 4 set, irq_o pulses high for one cycle when an advance makes the count equal to the target. With bit 4 clear, no such pulse occurs.
- R8: On channels 0 and 1, with mode bit 0 set and sync code (bits 2:1) 0, the count holds while blank_i is high.
- R9: On channels 0 and 1, with mode bit 0 set and sync code 1 or 2, the count clears to 0 in the cycle after blank_i falls. While blank_i is high the count keeps advancing.
- R10: On channel 0, in the clear-on-unblank codes, an advance from LINE_LEN-1 gives 0.
- R11: On channel 2, with mode bit 0 set and sync code 0 or 3, the count never advances. With sync code 1 or 2 it counts freely, and blank_i has no effect.
- R12: With mode bit 0 clear, or with sync code 3 on channels 0 and 1, blank_i has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 count, 1 mode, 2 target |
| wr_data_i | input | DATA_W | Write data |
| rd_sel_i | input | 2 | Read select: 0 count, 1 mode, 2 target, 3 zero |
| rd_data_o | output | CNT_W | Read data, combinational |
| sys_tick_i | input | 1 | System clock-enable pulse |
| alt_tick_i | input | 1 | Alternate source clock-enable pulse |
| blank_i | input | 1 | Blanking level from video timing |
| irq_o | output | 1 | Single-cycle interrupt pulse |

## Verification
A table of register writes and tick bursts drives channel 0 through free counting, a count load with stray upper bits, the step from 0xFFFF to 0, and repeated folding at a small target. These cases separate the full-range wrap from the target wrap. Directed runs then hold blanking high under each sync code on all three channels. They tell a pause apart from a clear at the falling edge, from a stopped channel 2 and from an ignored blank. Interrupt pulses are counted per event with each enable on and off. One case makes a mode write and a tick meet in the same cycle, to show that the write wins.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_MODE   = 2'd1,
    REG_TARGET = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SYNC_C0 = 2'd0,
    SYNC_C1 = 2'd1,
    SYNC_C2 = 2'd2,
    SYNC_C3 = 2'd3
  } sync_code_e;

  typedef struct packed {
    logic       alt_src;
    logic       irq_ovf;
    logic       irq_tgt;
    logic       tgt_wrap;
    sync_code_e sync_code;
    logic       sync_en;
  } mode_t;

  function automatic mode_t decode_mode(input logic [15:0] m);
    mode_t r;
    r.sync_en   = m[0];
    r.sync_code = sync_code_e'(m[2:1]);
    r.tgt_wrap  = m[3];
    r.irq_tgt   = m[4];
    r.irq_ovf   = m[5];
    r.alt_src   = m[8];
    return r;
  endfunction

endpackage

// File: rtl/timer_tick_gate.sv
module timer_tick_gate
  import timer_pkg::*;
#(
  parameter int unsigned INST = 0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_t mode_i,
  input  logic  sys_tick_i,
  input  logic  alt_tick_i,
  input  logic  blank_i,
  output logic  advance_o,
  output logic  sync_clr_o,
  output logic  line_wrap_o
);

  logic tick;
  assign tick = mode_i.alt_src ? alt_tick_i : sys_tick_i;

  generate
    if (INST == 2) begin : g_stop
      logic stop;
      logic unused_in;
      assign stop = mode_i.sync_en &&
                    (mode_i.sync_code == SYNC_C0 || mode_i.sync_code == SYNC_C3);
      assign advance_o   = tick & ~stop;
      assign sync_clr_o  = 1'b0;
      assign line_wrap_o = 1'b0;
      assign unused_in   = blank_i ^ clk_i ^ rst_ni;
    end else begin : g_sync
      logic blank_q;
      logic unblank;
      logic pause_mode;
      logic reset_mode;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) blank_q <= 1'b0;
        else         blank_q <= blank_i;
      end

      assign unblank    = blank_q & ~blank_i;
      assign pause_mode = mode_i.sync_en && mode_i.sync_code == SYNC_C0;
      assign reset_mode = mode_i.sync_en &&
                          (mode_i.sync_code == SYNC_C1 || mode_i.sync_code == SYNC_C2);

      assign advance_o   = tick & ~(pause_mode & blank_i);
      assign sync_clr_o  = reset_mode & unblank;
      assign line_wrap_o = reset_mode && (INST == 0);
    end
  endgenerate

endmodule

// File: rtl/timer_count_core.sv
module timer_count_core #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned LINE_LEN = 2146
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             sync_clr_i,
  input  logic             advance_i,
  input  logic             line_wrap_i,
  input  logic             tgt_wrap_i,
  input  logic [CNT_W-1:0] target_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tgt_evt_o,
  output logic             ovf_evt_o
);

  localparam logic [CNT_W-1:0] LINE_LAST = CNT_W'(LINE_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, inc;

  assign inc = cnt_q + CNT_W'(1);

  always_comb begin
    cnt_d     = cnt_q;
    tgt_evt_o = 1'b0;
    ovf_evt_o = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (load_i) begin
      cnt_d = load_val_i;
    end else if (sync_clr_i) begin
      cnt_d = '0;
    end else if (advance_i) begin
      if (tgt_wrap_i && cnt_q == target_i) begin
        cnt_d = '0;
      end else if (line_wrap_i && cnt_q == LINE_LAST) begin
        cnt_d = '0;
      end else begin
        cnt_d     = inc;
        ovf_evt_o = (cnt_q == CNT_MAX);
        tgt_evt_o = (inc == target_i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  logic quiet;
  assign quiet = !clr_i && !load_i && !sync_clr_i;

  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !clr_i |=> cnt_q == $past(load_val_i)); // R2
  AST_MODE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R3
  AST_OVF_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet && advance_i && cnt_q == CNT_MAX |=> cnt_q == '0); // R5
  AST_TGT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet && advance_i && tgt_wrap_i && cnt_q == target_i |=> cnt_q == '0); // R6
  AST_SYNC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_clr_i && !clr_i && !load_i |=> cnt_q == '0); // R9
  AST_LINE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet && advance_i && line_wrap_i && cnt_q == LINE_LAST |=> cnt_q == '0); // R10

endmodule

// File: rtl/timer_irq_gen.sv
module timer_irq_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tgt_evt_i,
  input  logic ovf_evt_i,
  input  logic en_tgt_i,
  input  logic en_ovf_i,
  output logic irq_o
);

  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (clr_i) irq_q <= 1'b0;
    else            irq_q <= (tgt_evt_i & en_tgt_i) | (ovf_evt_i & en_ovf_i);
  end

  assign irq_o = irq_q;

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(en_tgt_i | en_ovf_i)); // R7
  AST_IRQ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !irq_o); // R3

endmodule

// File: rtl/sync_timer.sv
module sync_timer
  import timer_pkg::*;
#(
  parameter int unsigned INST     = 0,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned LINE_LEN = 2146
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [CNT_W-1:0]  rd_data_o,
  input  logic              sys_tick_i,
  input  logic              alt_tick_i,
  input  logic              blank_i,
  output logic              irq_o
);

  logic [CNT_W-1:0] mode_q, target_q, count;
  logic             wr_cnt, wr_mode, wr_tgt;
  logic             advance, sync_clr, line_wrap, tgt_evt, ovf_evt;
  mode_t            mode;
  logic             unused_hi;

  assign wr_cnt    = wr_en_i && reg_sel_e'(wr_sel_i) == REG_COUNT;
  assign wr_mode   = wr_en_i && reg_sel_e'(wr_sel_i) == REG_MODE;
  assign wr_tgt    = wr_en_i && reg_sel_e'(wr_sel_i) == REG_TARGET;
  assign unused_hi = ^wr_data_i[DATA_W-1:CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      target_q <= '0;
    end else begin
      if (wr_mode) mode_q   <= wr_data_i[CNT_W-1:0];
      if (wr_tgt)  target_q <= wr_data_i[CNT_W-1:0];
    end
  end

  assign mode = decode_mode(16'(mode_q));

  always_comb begin
    unique case (reg_sel_e'(rd_sel_i))
      REG_COUNT:  rd_data_o = count;
      REG_MODE:   rd_data_o = mode_q;
      REG_TARGET: rd_data_o = target_q;
      default:    rd_data_o = '0;
    endcase
  end

  timer_tick_gate #(.INST(INST)) i_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .sys_tick_i (sys_tick_i),
    .alt_tick_i (alt_tick_i),
    .blank_i    (blank_i),
    .advance_o  (advance),
    .sync_clr_o (sync_clr),
    .line_wrap_o(line_wrap)
  );

  timer_count_core #(.CNT_W(CNT_W), .LINE_LEN(LINE_LEN)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (wr_mode),
    .load_i     (wr_cnt),
    .load_val_i (wr_data_i[CNT_W-1:0]),
    .sync_clr_i (sync_clr),
    .advance_i  (advance),
    .line_wrap_i(line_wrap),
    .tgt_wrap_i (mode.tgt_wrap),
    .target_i   (target_q),
    .count_o    (count),
    .tgt_evt_o  (tgt_evt),
    .ovf_evt_o  (ovf_evt)
  );

  timer_irq_gen i_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (wr_mode),
    .tgt_evt_i(tgt_evt),
    .ovf_evt_i(ovf_evt),
    .en_tgt_i (mode.irq_tgt),
    .en_ovf_i (mode.irq_ovf),
    .irq_o    (irq_o)
  );

  logic wr_any;
  assign wr_any = wr_cnt | wr_mode;

  generate
    if (INST == 2) begin : g_chk_stop
      AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode.sync_en && (mode.sync_code == SYNC_C0 || mode.sync_code == SYNC_C3)
        && !wr_any |=> $stable(count)); // R11
    end else begin : g_chk_sync
      AST_PAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode.sync_en && mode.sync_code == SYNC_C0 && blank_i && !wr_any
        |=> $stable(count)); // R8
    end
  endgenerate

  AST_SRC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_tick_i && !alt_tick_i && !wr_any && !sync_clr |=> $stable(count)); // R4

endmodule

// File: tb/test_sync_timer.sv
module test_sync_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  wr_en = '0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic        sys_tick = 1'b0;
  logic        alt_tick = 1'b0;
  logic        blank = 1'b0;
  logic [15:0] rd0, rd1, rd2;
  logic        irq0, irq1, irq2;

  int n_checks = 0;
  int n_errors = 0;
  int irq0_n = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sync_timer #(.INST(0), .LINE_LEN(12)) i_sync_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en[0]), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd0),
    .sys_tick_i(sys_tick), .alt_tick_i(alt_tick), .blank_i(blank), .irq_o(irq0));

  sync_timer #(.INST(1)) i_sync_timer_1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en[1]), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd1),
    .sys_tick_i(sys_tick), .alt_tick_i(alt_tick), .blank_i(blank), .irq_o(irq1));

  sync_timer #(.INST(2)) i_sync_timer_2 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en[2]), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd2),
    .sys_tick_i(sys_tick), .alt_tick_i(alt_tick), .blank_i(blank), .irq_o(irq2));

  always @(negedge clk) if (irq0) irq0_n++;

  typedef struct packed {
    logic        wr;
    logic [1:0]  sel;
    logic [31:0] data;
    logic [7:0]  ticks;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd1, 32'h0000_0000, 8'd5, 16'h0005},  // R4 base source counts
    '{1'b1, 2'd0, 32'h0001_FFFA, 8'd0, 16'hFFFA},  // R2 low bits only
    '{1'b0, 2'd0, 32'h0,         8'd5, 16'hFFFF},
    '{1'b0, 2'd0, 32'h0,         8'd1, 16'h0000},  // R5 full-range wrap
    '{1'b1, 2'd2, 32'h0000_0004, 8'd0, 16'h0000},
    '{1'b1, 2'd1, 32'h0000_0008, 8'd4, 16'h0004},
    '{1'b0, 2'd0, 32'h0,         8'd1, 16'h0000},  // R6 target wrap
    '{1'b0, 2'd0, 32'h0,         8'd7, 16'h0002},  // R6 repeated fold
    '{1'b1, 2'd0, 32'h0000_0003, 8'd0, 16'h0003}   // R2
  };

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input int inst, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = '0;
    wr_en[inst] = 1'b1;
    wr_sel = sel;
    wr_data = d;
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic ticks(input int n, input bit alt);
    if (n > 0) begin
      @(negedge clk);
      if (alt) alt_tick = 1'b1; else sys_tick = 1'b1;
      repeat (n) @(negedge clk);
      alt_tick = 1'b0;
      sys_tick = 1'b0;
    end
  endtask

  task automatic rd_chk(input int inst, input logic [1:0] sel, input string req,
                        input string what, input int exp);
    int v;
    rd_sel = sel;
    #1;
    v = (inst == 0) ? int'(rd0) : (inst == 1) ? int'(rd1) : int'(rd2);
    chk(req, what, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk(0, 2'd0, "R1", "count", 0);
    rd_chk(0, 2'd1, "R1", "mode", 0);
    rd_chk(0, 2'd2, "R1", "target", 0);
    chk("R1", "irq", int'(irq0), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(0, VEC[i].sel, VEC[i].data);
      ticks(int'(VEC[i].ticks), 1'b0);
      rd_chk(0, 2'd0, "R2/R4/R5/R6", $sformatf("vector %0d count", i), int'(VEC[i].exp));
    end
    rd_chk(0, 2'd2, "R2", "target readback", 4);
    rd_chk(0, 2'd1, "R2", "mode readback", 8);
    rd_chk(0, 2'd3, "R2", "unused select", 0);

    // R4 alternate source
    wr(0, 2'd1, 32'h0100);
    ticks(3, 1'b0);
    rd_chk(0, 2'd0, "R4", "base ignored", 0);
    ticks(2, 1'b1);
    rd_chk(0, 2'd0, "R4", "alt counted", 2);

    // R7 target interrupt
    wr(0, 2'd2, 32'h0003);
    wr(0, 2'd1, 32'h0018);
    base = irq0_n;
    ticks(3, 1'b0);
    @(negedge clk);
    rd_chk(0, 2'd0, "R7", "count at target", 3);
    chk("R7", "one pulse", irq0_n - base, 1);
    ticks(5, 1'b0);
    @(negedge clk);
    chk("R7", "second pulse", irq0_n - base, 2);
    wr(0, 2'd1, 32'h0008);
    base = irq0_n;
    ticks(4, 1'b0);
    @(negedge clk);
    chk("R7", "disabled", irq0_n - base, 0);

    // R5 overflow interrupt
    wr(0, 2'd1, 32'h0020);
    wr(0, 2'd0, 32'h0000_FFFE);
    base = irq0_n;
    ticks(2, 1'b0);
    @(negedge clk);
    rd_chk(0, 2'd0, "R5", "wrapped", 0);
    chk("R5", "overflow pulse", irq0_n - base, 1);

    // R3 mode write beats a tick in the same cycle
    wr(0, 2'd0, 32'h0000_FFFF);
    base = irq0_n;
    @(negedge clk);
    wr_en[0] = 1'b1;
    wr_sel = 2'd1;
    wr_data = 32'h0020;
    sys_tick = 1'b1;
    @(negedge clk);
    wr_en = '0;
    sys_tick = 1'b0;
    @(negedge clk);
    rd_chk(0, 2'd0, "R3", "count cleared", 0);
    chk("R3", "no pulse", irq0_n - base, 0);

    // R8 pause during blank
    wr(0, 2'd1, 32'h0001);
    blank = 1'b1;
    ticks(4, 1'b0);
    rd_chk(0, 2'd0, "R8", "paused", 0);
    blank = 1'b0;
    ticks(3, 1'b0);
    rd_chk(0, 2'd0, "R8", "resumed", 3);

    // R12 sync off: blank ignored
    wr(0, 2'd1, 32'h0000);
    blank = 1'b1;
    ticks(3, 1'b0);
    rd_chk(0, 2'd0, "R12", "sync off", 3);
    blank = 1'b0;

    // R9 clear on unblank, channel 0 code 1
    wr(0, 2'd1, 32'h0003);
    ticks(5, 1'b0);
    blank = 1'b1;
    ticks(2, 1'b0);
    rd_chk(0, 2'd0, "R9", "counts in blank", 7);
    @(negedge clk);
    blank = 1'b0;
    @(negedge clk);
    rd_chk(0, 2'd0, "R9", "cleared", 0);

    // R10 line wrap, LINE_LEN 12
    ticks(11, 1'b0);
    rd_chk(0, 2'd0, "R10", "last", 11);
    ticks(1, 1'b0);
    rd_chk(0, 2'd0, "R10", "fold", 0);
    ticks(14, 1'b0);
    rd_chk(0, 2'd0, "R10", "fold again", 2);

    // R9 channel 1 code 2, no line wrap
    wr(1, 2'd1, 32'h0005);
    ticks(20, 1'b0);
    blank = 1'b1;
    ticks(1, 1'b0);
    rd_chk(1, 2'd0, "R9", "ch1 count", 21);
    @(negedge clk);
    blank = 1'b0;
    @(negedge clk);
    rd_chk(1, 2'd0, "R9", "ch1 cleared", 0);

    // R12 code 3 on channel 1
    wr(1, 2'd1, 32'h0007);
    blank = 1'b1;
    ticks(4, 1'b0);
    blank = 1'b0;
    repeat (2) @(negedge clk);
    rd_chk(1, 2'd0, "R12", "code 3 free", 4);

    // R11 channel 2 stop codes
    wr(2, 2'd1, 32'h0001);
    ticks(5, 1'b0);
    rd_chk(2, 2'd0, "R11", "code 0 frozen", 0);
    wr(2, 2'd1, 32'h0007);
    ticks(5, 1'b0);
    rd_chk(2, 2'd0, "R11", "code 3 frozen", 0);
    wr(2, 2'd1, 32'h0003);
    ticks(5, 1'b0);
    blank = 1'b1;
    ticks(2, 1'b0);
    blank = 1'b0;
    repeat (2) @(negedge clk);
    rd_chk(2, 2'd0, "R11", "code 1 counts, blank ignored", 7);
    wr(2, 2'd1, 32'h0005);
    ticks(3, 1'b0);
    rd_chk(2, 2'd0, "R11", "code 2 counts", 3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule